// File: doc/BRIEF.md
# Slice Capture Memory with Offset Readback

This block keeps a rolling history of sampled data for a group of channels. While the `run` input is high, every clock tick stores one 8-bit sample per channel into an input memory and another into an output memory. The write pointer advances by one each tick and wraps around a 256-entry ring, so consecutive addresses hold consecutive time slices. When `run` drops, writing stops and the address written last is kept as the reference point.

A readout begins with a `start` pulse while the block is halted. The block reads back a programmed number of slices, beginning a programmed number of slices before the reference point. It steps through the wanted channel pairs in ascending order. Within each pair it reads the input memory first, then the output memory, as the type mask selects. Each 16-bit word carries one sample from each channel of the current pair. The host takes a word with a one-cycle read strobe. The block fetches the next word, and it raises `done` once the last word has been taken.

Top module: `slice_capture_mem`

## Requirements
- R1: While `run` is high, each rising clock edge writes every channel's input and output sample at the write pointer, and the pointer then advances by one modulo 256. While `run` is low, nothing is written and the pointer holds.
- R2: Each memory's readout starts at address (last written address − `slice_offset`) mod 256. Successive slices take successive addresses, wrapping modulo 256.
- R3: `rd_data[7:0]` carries the even channel of the current pair and `rd_data[15:8]` the odd channel (pair p = channels 2p and 2p+1).
- R4: `type_mask` bit 0 selects the input memory and bit 1 the output memory. Within a pair, input is read before output. `rd_mtype` reports 1 for input, 2 for output, and 0 when no word is valid.
- R5: `rd_valid` rises one cycle after an accepted `start`, and one cycle after each `rd_strobe` that takes a word, unless the readout has ended. While `rd_valid` is high and no strobe arrives, `rd_data` holds.
- R6: Pairs are read in ascending order. Pair p is skipped only when both `skip_mask` bits 2p and 2p+1 are one.
- R7: One cycle after the last word is taken, `done` is 1 and `busy` is 0. `done` and `busy` are never high together.
- R8: If the slice count is 0, the type mask is 0, or every pair is skipped, `done` rises one cycle after `start` and no word is produced.
- R9: A slice count above 248 is treated as 248. `rd_slice` never reaches 248.
- R10: `start` is ignored while `run` is high. Raising `run` during a readout clears `busy`, `rd_valid` and `done` on the next edge.
- R11: The offset, count, type mask and skip mask are latched on the accepted `start`. Later changes to them do not alter the readout in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and readout clock, one tick per slice |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High: capture samples; low: halted, readout allowed |
| in_samples | input | NUM_CH*8 (32) | Input-memory samples, channel c at bits [8c+7:8c] |
| out_samples | input | NUM_CH*8 (32) | Output-memory samples, same packing |
| start | input | 1 | Pulse to begin a readout while halted |
| rd_strobe | input | 1 | Takes the current word when `rd_valid` is high |
| slice_offset | input | 8 | Slices back from the last written address |
| slice_count | input | 8 | Slices per memory to read, saturated at 248 |
| type_mask | input | 2 | Bit 0 input memory, bit 1 output memory |
| skip_mask | input | NUM_CH (4) | Not-wanted bits, one per channel |
| rd_data | output | 16 | Pair word: odd channel high byte, even channel low byte |
| rd_valid | output | 1 | `rd_data` holds a word ready to take |
| rd_pair | output | PAIR_W (1) | Pair index of the current word |
| rd_mtype | output | 2 | Memory type of the current word (1 input, 2 output) |
| rd_slice | output | 8 | Slice index of the current word within its memory |
| busy | output | 1 | Readout in progress |
| done | output | 1 | Last readout finished |

## Verification
Every result follows from a fixed cycle count. An empty readout sets `done` on the edge that takes `start`. The first word is valid one edge after that. Each later word becomes valid one edge after the strobe edge that took the previous word. `done` follows the last strobe edge.

The bench drives inputs on the falling edge and samples on the next falling edge, so each check falls half a cycle after the edge that produced the value. Before reading a word, the bench waits for `rd_valid` with a bounded count of cycles. It keeps its own model of the ring contents and the write pointer, and it compares every returned word against that model.

// File: rtl/slicemem_pkg.sv
package slicemem_pkg;
  // Memory type codes reported with each readout word
  typedef enum logic [1:0] {
    MT_NONE   = 2'd0,
    MT_INPUT  = 2'd1,
    MT_OUTPUT = 2'd2
  } mem_type_e;
endpackage

// File: rtl/slice_ram.sv
// Simple dual-port ring memory with registered read, block RAM friendly
module slice_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/capture_ctrl.sv
// Write pointer and last-written reference for the capture ring
module capture_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] last_addr
);
  logic [ADDR_W-1:0] wr_ptr;

  assign wr_en   = run;
  assign wr_addr = wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      last_addr <= '1;
    end else if (run) begin
      wr_ptr    <= wr_ptr + 1'b1;
      last_addr <= wr_ptr;
    end
  end
endmodule

// File: rtl/readout_seq.sv
// Walks wanted (pair, type) units and slices, producing the read address
module readout_seq #(
  parameter int NUM_PAIRS  = 2,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int MAX_SLICES = 248,
  parameter int PAIR_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  parameter int UNIT_W     = PAIR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   start,
  input  logic                   strobe,
  input  logic [ADDR_W-1:0]      offset,
  input  logic [CNT_W-1:0]       slices,
  input  logic [1:0]             type_mask,
  input  logic [2*NUM_PAIRS-1:0] skip_mask,
  input  logic [ADDR_W-1:0]      last_addr,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic [UNIT_W-1:0]      unit,
  output logic [CNT_W-1:0]       slice_idx,
  output logic                   valid,
  output logic                   busy,
  output logic                   done
);
  localparam int NUM_UNITS = 2 * NUM_PAIRS;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_SLICES);

  logic [NUM_UNITS-1:0] want_now, lat_units;
  logic [CNT_W-1:0]     count_now, lat_count;
  logic [ADDR_W-1:0]    base_now, lat_base;
  logic [UNIT_W:0]      first_u, next_u;

  // Lowest set unit at index >= from; MSB flags a hit
  function automatic logic [UNIT_W:0] find_unit(input logic [NUM_UNITS-1:0] m,
                                                input int from);
    logic [UNIT_W:0] r;
    r = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (i >= from && m[i]) r = {1'b1, UNIT_W'(i)};
    end
    return r;
  endfunction

  always_comb begin
    for (int p = 0; p < NUM_PAIRS; p++) begin
      for (int t = 0; t < 2; t++) begin
        want_now[2*p+t] = ~(skip_mask[2*p] & skip_mask[2*p+1]) & type_mask[t];
      end
    end
  end

  assign count_now = (slices > CAP) ? CAP : slices;
  assign base_now  = last_addr - offset;
  assign first_u   = find_unit(want_now, 0);
  assign next_u    = find_unit(lat_units, int'(unit) + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      valid     <= 1'b0;
      done      <= 1'b0;
      unit      <= '0;
      slice_idx <= '0;
      rd_addr   <= '0;
      lat_units <= '0;
      lat_count <= '0;
      lat_base  <= '0;
    end else if (run) begin
      busy  <= 1'b0;
      valid <= 1'b0;
      done  <= 1'b0;
    end else if (start && !busy) begin
      lat_units <= want_now;
      lat_count <= count_now;
      lat_base  <= base_now;
      valid     <= 1'b0;
      slice_idx <= '0;
      rd_addr   <= base_now;
      if (count_now == '0 || !first_u[UNIT_W]) begin
        done <= 1'b1;
        busy <= 1'b0;
      end else begin
        done <= 1'b0;
        busy <= 1'b1;
        unit <= first_u[UNIT_W-1:0];
      end
    end else if (busy) begin
      if (!valid) begin
        valid <= 1'b1;
      end else if (strobe) begin
        valid <= 1'b0;
        if (slice_idx == lat_count - CNT_W'(1)) begin
          if (next_u[UNIT_W]) begin
            unit      <= next_u[UNIT_W-1:0];
            slice_idx <= '0;
            rd_addr   <= lat_base;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          slice_idx <= slice_idx + 1'b1;
          rd_addr   <= rd_addr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slice_capture_mem.sv
module slice_capture_mem
  import slicemem_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int SAMPLE_W   = 8,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int MAX_SLICES = 248,
  parameter int NUM_PAIRS  = NUM_CH / 2,
  parameter int PAIR_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic [NUM_CH*SAMPLE_W-1:0] in_samples,
  input  logic [NUM_CH*SAMPLE_W-1:0] out_samples,
  input  logic                     start,
  input  logic                     rd_strobe,
  input  logic [ADDR_W-1:0]        slice_offset,
  input  logic [CNT_W-1:0]         slice_count,
  input  logic [1:0]               type_mask,
  input  logic [NUM_CH-1:0]        skip_mask,
  output logic [2*SAMPLE_W-1:0]    rd_data,
  output logic                     rd_valid,
  output logic [PAIR_W-1:0]        rd_pair,
  output logic [1:0]               rd_mtype,
  output logic [CNT_W-1:0]         rd_slice,
  output logic                     busy,
  output logic                     done
);
  localparam int UNIT_W = PAIR_W + 1;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, last_addr, rd_addr;
  logic [UNIT_W-1:0] unit;
  logic [SAMPLE_W-1:0] in_q  [NUM_CH];
  logic [SAMPLE_W-1:0] out_q [NUM_CH];
  logic [SAMPLE_W-1:0] lo_byte, hi_byte;
  logic              cur_type;
  logic [PAIR_W-1:0] cur_pair;

  capture_ctrl #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .last_addr(last_addr)
  );

  readout_seq #(
    .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .MAX_SLICES(MAX_SLICES), .PAIR_W(PAIR_W), .UNIT_W(UNIT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .run(run), .start(start), .strobe(rd_strobe),
    .offset(slice_offset), .slices(slice_count), .type_mask(type_mask),
    .skip_mask(skip_mask), .last_addr(last_addr), .rd_addr(rd_addr),
    .unit(unit), .slice_idx(rd_slice), .valid(rd_valid), .busy(busy),
    .done(done)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      slice_ram #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_in_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr),
        .wdata(in_samples[c*SAMPLE_W +: SAMPLE_W]),
        .raddr(rd_addr), .rdata(in_q[c])
      );
      slice_ram #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_out_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr),
        .wdata(out_samples[c*SAMPLE_W +: SAMPLE_W]),
        .raddr(rd_addr), .rdata(out_q[c])
      );
    end
  endgenerate

  assign cur_type = unit[0];
  assign cur_pair = unit[UNIT_W-1:1];
  assign rd_pair  = cur_pair;

  always_comb begin
    lo_byte = '0;
    hi_byte = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (cur_pair == PAIR_W'(p)) begin
        lo_byte = cur_type ? out_q[2*p]   : in_q[2*p];
        hi_byte = cur_type ? out_q[2*p+1] : in_q[2*p+1];
      end
    end
    rd_data  = rd_valid ? {hi_byte, lo_byte} : '0;
    rd_mtype = !rd_valid ? MT_NONE : (cur_type ? MT_OUTPUT : MT_INPUT);
  end
endmodule

// File: rtl/slice_capture_mem_chk.sv
module slice_capture_mem_chk #(
  parameter int CNT_W      = 8,
  parameter int MAX_SLICES = 248
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             start,
  input logic             rd_strobe,
  input logic [CNT_W-1:0] slice_count,
  input logic [1:0]       type_mask,
  input logic [15:0]      rd_data,
  input logic             rd_valid,
  input logic [1:0]       rd_mtype,
  input logic [CNT_W-1:0] rd_slice,
  input logic             busy,
  input logic             done
);
  assert_valid_needs_busy_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);
  assert_word_arrives_R5: assert property (@(posedge clk) disable iff (rst)
    busy && !rd_valid && !run |=> rd_valid);
  assert_strobe_takes_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_strobe && !run |=> !rd_valid);
  assert_word_holds_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_strobe && !run |=> rd_valid && $stable(rd_data));
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_empty_start_R8: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !run && (slice_count == '0 || type_mask == 2'b00)
    |=> done && !busy && !rd_valid);
  assert_slice_cap_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_slice < CNT_W'(MAX_SLICES));
  assert_type_code_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $countones(rd_mtype) == 1);
  assert_run_aborts_R10: assert property (@(posedge clk) disable iff (rst)
    run |=> !busy && !rd_valid && !done);
endmodule

bind slice_capture_mem slice_capture_mem_chk #(
  .CNT_W(CNT_W), .MAX_SLICES(MAX_SLICES)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .start(start), .rd_strobe(rd_strobe),
  .slice_count(slice_count), .type_mask(type_mask), .rd_data(rd_data),
  .rd_valid(rd_valid), .rd_mtype(rd_mtype), .rd_slice(rd_slice),
  .busy(busy), .done(done)
);

// File: tb/tb_slice_capture_mem.sv
module tb_slice_capture_mem;
  localparam int NUM_CH = 4;

  logic        clk = 0, rst = 1, run = 0, start = 0, rd_strobe = 0;
  logic [31:0] in_samples = '0, out_samples = '0;
  logic [7:0]  slice_offset = '0, slice_count = '0;
  logic [1:0]  type_mask = '0;
  logic [3:0]  skip_mask = '0;
  logic [15:0] rd_data;
  logic        rd_valid, busy, done;
  logic [0:0]  rd_pair;
  logic [1:0]  rd_mtype;
  logic [7:0]  rd_slice;

  int checks = 0, errors = 0;
  int ptr = 0, gtick = 0;
  logic [7:0] m_in  [NUM_CH][256];
  logic [7:0] m_out [NUM_CH][256];

  always #10 clk = ~clk;

  slice_capture_mem dut (
    .clk(clk), .rst(rst), .run(run), .in_samples(in_samples),
    .out_samples(out_samples), .start(start), .rd_strobe(rd_strobe),
    .slice_offset(slice_offset), .slice_count(slice_count),
    .type_mask(type_mask), .skip_mask(skip_mask), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_pair(rd_pair), .rd_mtype(rd_mtype),
    .rd_slice(rd_slice), .busy(busy), .done(done)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Present one tick of samples; the next rising edge writes them (R1)
  task automatic put_samples();
    for (int c = 0; c < NUM_CH; c++) begin
      m_in[c][ptr]  = 8'((gtick * 7 + c * 61 + 5) & 255);
      m_out[c][ptr] = 8'((gtick * 13 + c * 29 + 171) & 255);
      in_samples[c*8 +: 8]  = m_in[c][ptr];
      out_samples[c*8 +: 8] = m_out[c][ptr];
    end
    ptr = (ptr + 1) % 256;
    gtick++;
  endtask

  task automatic capture(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      run = 1;
      put_samples();
    end
    @(negedge clk);
    run = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_valid(string req);
    int guard = 0;
    while (!rd_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    check_eq(req, "rd_valid", int'(rd_valid), 1);
  endtask

  task automatic readout(string req, int off, int cnt, int tmask, int skip);
    int last = (ptr + 255) % 256;
    int base = (last - off + 256) % 256;
    int eff  = (cnt > 248) ? 248 : cnt;
    bit any_pair = 0;
    for (int p = 0; p < NUM_CH / 2; p++)
      if (!(skip[2*p] && skip[2*p+1])) any_pair = 1;
    @(negedge clk);
    slice_offset = 8'(off); slice_count = 8'(cnt);
    type_mask = 2'(tmask); skip_mask = 4'(skip);
    start = 1;
    @(negedge clk);
    start = 0;
    // Scramble configuration after start: must not matter (R11)
    slice_offset = ~slice_offset; slice_count = 8'd3;
    type_mask = ~type_mask; skip_mask = ~skip_mask;
    if (eff == 0 || tmask == 0 || !any_pair) begin
      check_eq(req, "empty done", int'(done), 1);
      check_eq(req, "empty busy", int'(busy), 0);
      check_eq(req, "empty valid", int'(rd_valid), 0);
      @(negedge clk);
      check_eq(req, "empty no word", int'(rd_valid), 0);
      return;
    end
    for (int p = 0; p < NUM_CH / 2; p++) begin
      if (skip[2*p] && skip[2*p+1]) continue;
      for (int t = 0; t < 2; t++) begin
        if (!tmask[t]) continue;
        for (int s = 0; s < eff; s++) begin
          int a = (base + s) % 256;
          int lo = (t == 0) ? m_in[2*p][a]   : m_out[2*p][a];
          int hi = (t == 0) ? m_in[2*p+1][a] : m_out[2*p+1][a];
          wait_valid(req);
          check_eq(req, "rd_data", int'(rd_data), hi * 256 + lo);
          check_eq(req, "rd_pair", int'(rd_pair), p);
          check_eq(req, "rd_mtype", int'(rd_mtype), t + 1);
          check_eq(req, "rd_slice", int'(rd_slice), s);
          rd_strobe = 1;
          @(negedge clk);
          rd_strobe = 0;
        end
      end
    end
    check_eq({req, " R7"}, "done", int'(done), 1);
    check_eq({req, " R7"}, "busy", int'(busy), 0);
  endtask

  task automatic t_reset();
    check_eq("reset", "busy", int'(busy), 0);
    check_eq("reset", "done", int'(done), 0);
    check_eq("reset", "rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_basic();
    capture(40);
    readout("R1 R2 R3 R11", 10, 5, 1, 0);
    readout("R1 latest", 0, 1, 1, 0);
  endtask

  task automatic t_types();
    readout("R4", 3, 4, 3, 0);
    readout("R4 output only", 6, 2, 2, 0);
  endtask

  task automatic t_skip();
    readout("R6 pair0 skipped", 2, 3, 3, 4'b0011);
    readout("R6 one zero bit each", 0, 2, 2, 4'b0110);
    readout("R8 all skipped", 0, 5, 3, 4'b1111);
  endtask

  task automatic t_wrap();
    capture(300);
    readout("R2 wrap", 100, 30, 1, 4'b1100);
  endtask

  task automatic t_zero();
    readout("R8 zero count", 5, 0, 3, 0);
    readout("R8 type mask zero", 5, 4, 0, 0);
  endtask

  task automatic t_clamp();
    readout("R9", 0, 255, 1, 4'b1100);
  endtask

  task automatic t_run_control();
    // Start while running is ignored (R10)
    @(negedge clk);
    slice_count = 8'd4; type_mask = 2'b01; skip_mask = '0;
    run = 1; start = 1;
    put_samples();
    @(negedge clk);
    run = 0; start = 0;
    check_eq("R10 start ignored", "busy", int'(busy), 0);
    @(negedge clk);
    check_eq("R10 start ignored", "rd_valid", int'(rd_valid), 0);
    // Raising run aborts a readout (R10)
    @(negedge clk);
    slice_offset = 8'd1; start = 1;
    @(negedge clk);
    start = 0;
    wait_valid("R10 abort setup");
    run = 1;
    put_samples();
    @(negedge clk);
    run = 0;
    check_eq("R10 abort", "busy", int'(busy), 0);
    check_eq("R10 abort", "rd_valid", int'(rd_valid), 0);
    check_eq("R10 abort", "done", int'(done), 0);
    readout("R1 after abort", 0, 2, 3, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_types();
        t_skip();
        t_wrap();
        t_zero();
        t_clamp();
        t_run_control();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule